// File: doc/BRIEF.md
# Performance Monitor Counter Unit

A bank of four up-counting 32-bit event counters that measure how often selected activities occur inside a processor. Every counter picks one bit of a shared vector of single-cycle event pulses, and it advances by one on each selected pulse unless something freezes it. It can be frozen for the whole bank, on its own, by the current privilege level (supervisor or user), or by the level of a mark input.

Software sets a sampling period by loading a counter with 0x80000000 minus N. After N events the counter's top bit becomes set. If that counter's condition enable is on, this is a condition. A condition raises the interrupt output when interrupts are enabled. When the matching global option is on, a condition also freezes the whole bank in the same cycle. All registers are reached through a word-addressed synchronous write port and a combinational read port.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset the global control register reads 0x80000000, each local control register reads 0xF8000000, every count register reads 0 and `irq` is 0.
- R2: Word address 0 is global control, addresses 1..4 are local control of counters 0..3, and addresses 5..8 are counts 0..3. Any other address reads 0, and a write to it changes no register.
- R3: While the global freeze bit (bit 31 of global control) is set, no counter changes except by a software write.
- R4: Local control bit 31 freezes that counter. Bit 30 freezes it while `priv_sup` is 1 (supervisor), and bit 29 freezes it while `priv_sup` is 0 (user).
- R5: Local control bit 28 freezes the counter while `mark_in` is 1, and bit 27 freezes it while `mark_in` is 0.
- R6: Local control bits [23:16] select the event bit. A value of 32 or above never counts. Only bits 31..26 and 23..16 are stored, and all other bits read as 0.
- R7: An unfrozen counter adds 1 at the clock edge on which its selected pulse is high, and it wraps from 0xFFFFFFFF to 0. A software write to a count register wins over an increment in the same cycle.
- R8: `irq` is high while global bit 30 (interrupt enable) is set and at least one counter has local bit 26 (condition enable) set together with count bit 31. Writing that count with bit 31 clear removes the condition.
- R9: When global bit 29 (freeze on condition) is set and a condition is present, counting stops in that same cycle and global bit 31 is set at the next edge. This hardware set wins over a software write that clears bit 31.
- R10: A counter preloaded with 0x80000000 minus N, with condition enable set, shows its condition after exactly N counted events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_pulse | input | 32 | Single-cycle event pulses |
| priv_sup | input | 1 | 1 for supervisor level, 0 for user level |
| mark_in | input | 1 | Mark state level |
| irq | output | 1 | Overflow-condition interrupt |

## Verification
A register write and an event pulse both act on the single clock edge after they are driven. The bench drives them just after a falling edge and reads back at the next falling edge. At that point every count and control value is one edge old. The interrupt output is combinational from the registers, so it is due at that same falling edge. The auto-freeze shows at once as a halted count, and as the global freeze bit one edge later. The bench reads the global register only after a further cycle, so it never samples between those two events.

// File: rtl/pmu_pkg.sv
// Package: shared widths and field positions of the performance monitor.
// Assumes 32-bit registers and word addressing.
package pmu_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;

    // Local control field positions
    localparam int L_FRZ   = 31;
    localparam int L_FSUP  = 30;
    localparam int L_FUSR  = 29;
    localparam int L_FMK1  = 28;
    localparam int L_FMK0  = 27;
    localparam int L_CEN   = 26;
    localparam int L_SEL_LO = 16;

    // Global control field positions
    localparam int G_FRZALL = 31;
    localparam int G_IRQEN  = 30;
    localparam int G_FOC    = 29;

    typedef struct packed {
        logic             frz;
        logic             frz_sup;
        logic             frz_usr;
        logic             frz_mk1;
        logic             frz_mk0;
        logic             cond_en;
        logic [SEL_W-1:0] evsel;
    } lcl_ctrl_t;

    localparam lcl_ctrl_t LCL_RESET = '{frz: 1'b1, frz_sup: 1'b1, frz_usr: 1'b1,
                                        frz_mk1: 1'b1, frz_mk0: 1'b1, cond_en: 1'b0,
                                        evsel: '0};

    // Place local control fields into their register view.
    function automatic logic [DATA_W-1:0] lcl_to_word(lcl_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[L_FRZ]  = c.frz;
        w[L_FSUP] = c.frz_sup;
        w[L_FUSR] = c.frz_usr;
        w[L_FMK1] = c.frz_mk1;
        w[L_FMK0] = c.frz_mk0;
        w[L_CEN]  = c.cond_en;
        w[L_SEL_LO +: SEL_W] = c.evsel;
        return w;
    endfunction
endpackage

// File: rtl/pmu_event_select.sv
// Module: picks one event pulse by index.
// Assumes the pulses are single-cycle and synchronous. Any index beyond the
// vector width gives a constant 0.
module pmu_event_select #(
    parameter int EVT_W = 32,
    parameter int SEL_W = 8
) (
    input  logic [EVT_W-1:0] evt,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    localparam int IW = (EVT_W > 1) ? $clog2(EVT_W) : 1;

    generate
        if (SEL_W > IW) begin : g_wide
            // Upper index bits must be zero; the low bits pick the pulse.
            always_comb begin
                hit = 1'b0;
                if (sel[SEL_W-1:IW] == '0 && 32'(sel[IW-1:0]) < EVT_W)
                    hit = evt[sel[IW-1:0]];
            end
        end else begin : g_narrow
            // The index fits; range-check it against the vector width.
            always_comb begin
                hit = 1'b0;
                if (32'(sel) < EVT_W)
                    hit = evt[sel];
            end
        end
    endgenerate
endmodule

// File: rtl/pmu_global_ctrl.sv
// Module: global control register with freeze-all, interrupt enable and
// freeze-on-condition. Assumes any_cond is the OR of the counters' enabled
// conditions from the current register state. The hardware freeze wins over a
// software clear in the same cycle.
module pmu_global_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wbits,      // {freeze-all, irq enable, freeze on cond}
    input  logic       any_cond,
    output logic       frz_all_eff,
    output logic       irq_en,
    output logic       frz_on_cond,
    output logic       frz_all
);
    logic set_req;
    logic past_ok;

    // Hardware freeze request from an enabled condition.
    assign set_req     = frz_on_cond & any_cond;
    assign frz_all_eff = frz_all | set_req;

    // Global control register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_all     <= 1'b1;
            irq_en      <= 1'b0;
            frz_on_cond <= 1'b0;
        end else if (wr) begin
            frz_all     <= wbits[2] | set_req;
            irq_en      <= wbits[1];
            frz_on_cond <= wbits[0];
        end else begin
            frz_all     <= frz_all | set_req;
        end
    end

    // Marks cycles whose past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a condition under freeze-on-condition leaves freeze-all set.
    a_r9_autofreeze_sets: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(set_req) |-> frz_all);

    // R3: freeze-all clears only through a software write.
    a_r3_freeze_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(frz_all) && !$past(wr) |-> frz_all);
endmodule

// File: rtl/pmu_counter_slice.sv
// Module: one counter with its local control register, freeze
// qualification and condition output. Assumes priv_sup, mark_in and the
// event pulses are sampled on the same edge. A count write has priority
// over an increment.
module pmu_counter_slice
    import pmu_pkg::*;
#(
    parameter int EVT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_wr,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    input  logic              priv_sup,
    input  logic              mark_in,
    input  logic              frz_all_eff,
    output logic [DATA_W-1:0] lcl_word,
    output logic [DATA_W-1:0] cnt_q,
    output logic              cond
);
    lcl_ctrl_t lcl_q;
    logic      evt_hit;
    logic      qual_frz;
    logic      inc;
    logic      past_ok;

    pmu_event_select #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
        .evt (evt),
        .sel (lcl_q.evsel),
        .hit (evt_hit)
    );

    // Freeze qualifiers from the local register, privilege level and mark.
    always_comb begin
        qual_frz = lcl_q.frz
                 | (lcl_q.frz_sup &  priv_sup)
                 | (lcl_q.frz_usr & ~priv_sup)
                 | (lcl_q.frz_mk1 &  mark_in)
                 | (lcl_q.frz_mk0 & ~mark_in);
        inc = evt_hit & ~qual_frz & ~frz_all_eff;
    end

    // Local control register: only defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcl_q <= LCL_RESET;
        end else if (lcl_wr) begin
            lcl_q <= '{frz: wdata[L_FRZ], frz_sup: wdata[L_FSUP],
                       frz_usr: wdata[L_FUSR], frz_mk1: wdata[L_FMK1],
                       frz_mk0: wdata[L_FMK0], cond_en: wdata[L_CEN],
                       evsel: wdata[L_SEL_LO +: SEL_W]};
        end
    end

    // Count register: software write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    assign lcl_word = lcl_to_word(lcl_q);
    assign cond     = lcl_q.cond_en & cnt_q[DATA_W-1];

    // Marks cycles whose past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7: a count write lands exactly, whatever the event input.
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cnt_wr) |-> cnt_q == $past(wdata));

    // R7: without a write the count holds or steps by one.
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cnt_wr) |->
            (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1));

    // R3: the global freeze (registered or same-cycle) holds the count.
    a_r3_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(frz_all_eff) && !$past(cnt_wr) |-> $stable(cnt_q));

    // R4: the local freeze bit holds the count.
    a_r4_local_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(lcl_q.frz) && !$past(cnt_wr) |-> $stable(cnt_q));
endmodule

// File: rtl/pmu_counter_bank.sv
// Module: top of the performance monitor. It holds NUM_CNT counter slices,
// the global control register, address decode, the read mux and the
// interrupt. Address 0 is global control, 1..NUM_CNT are local controls,
// and NUM_CNT+1..2*NUM_CNT are counts. Other addresses read 0.
module pmu_counter_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int EVT_W   = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0]  evt_pulse,
    input  logic              priv_sup,
    input  logic              mark_in,
    output logic              irq
);
    localparam int LCL_BASE = 1;
    localparam int CNT_BASE = LCL_BASE + NUM_CNT;

    logic [DATA_W-1:0] lcl_word [NUM_CNT];
    logic [DATA_W-1:0] cnt_word [NUM_CNT];
    logic [NUM_CNT-1:0] cond_vec;
    logic               any_cond;
    logic               glb_wr;
    logic               frz_all_eff, irq_en, frz_on_cond, frz_all;

    assign glb_wr   = reg_wr && (reg_addr == '0);
    assign any_cond = |cond_vec;

    pmu_global_ctrl u_glb (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (glb_wr),
        .wbits       ({reg_wdata[G_FRZALL], reg_wdata[G_IRQEN], reg_wdata[G_FOC]}),
        .any_cond    (any_cond),
        .frz_all_eff (frz_all_eff),
        .irq_en      (irq_en),
        .frz_on_cond (frz_on_cond),
        .frz_all     (frz_all)
    );

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic lwr, cwr;
            assign lwr = reg_wr && (reg_addr == ADDR_W'(LCL_BASE + i));
            assign cwr = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + i));

            pmu_counter_slice #(.EVT_W(EVT_W)) u_slice (
                .clk         (clk),
                .rst_n       (rst_n),
                .lcl_wr      (lwr),
                .cnt_wr      (cwr),
                .wdata       (reg_wdata),
                .evt         (evt_pulse),
                .priv_sup    (priv_sup),
                .mark_in     (mark_in),
                .frz_all_eff (frz_all_eff),
                .lcl_word    (lcl_word[i]),
                .cnt_q       (cnt_word[i]),
                .cond        (cond_vec[i])
            );
        end
    endgenerate

    // Read mux over the word address map.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[G_FRZALL] = frz_all;
            reg_rdata[G_IRQEN]  = irq_en;
            reg_rdata[G_FOC]    = frz_on_cond;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(LCL_BASE + i)) reg_rdata = lcl_word[i];
            if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata = cnt_word[i];
        end
    end

    // Interrupt while enabled and any enabled condition is present.
    assign irq = irq_en & any_cond;

    // R8: the interrupt is never high while interrupts are disabled.
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: tb/sim_pmu_counter_bank.sv
module sim_pmu_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic        priv_sup = 1'b0;
    logic        mark_in = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmu_counter_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .priv_sup(priv_sup), .mark_in(mark_in), .irq(irq)
    );

    // Vector: [66:35] local ctrl, [34] priv_sup, [33] mark_in,
    // [32:1] event pulses, [0] expected increment of counter 0.
    localparam logic [66:0] VEC [NV] = '{
        {32'h0003_0000, 1'b0, 1'b0, 32'h0000_0008, 1'b1}, // R6 sel 3 hit
        {32'h0003_0000, 1'b0, 1'b0, 32'h0000_0010, 1'b0}, // R6 other bit
        {32'h0028_0000, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R6 index 40
        {32'h001F_0000, 1'b1, 1'b1, 32'h8000_0000, 1'b1}, // R6 sel 31
        {32'h8000_0000, 1'b0, 1'b0, 32'h0000_0001, 1'b0}, // R4 local freeze
        {32'h4000_0000, 1'b1, 1'b0, 32'h0000_0001, 1'b0}, // R4 sup frozen
        {32'h4000_0000, 1'b0, 1'b0, 32'h0000_0001, 1'b1}, // R4 sup, user run
        {32'h2000_0000, 1'b0, 1'b0, 32'h0000_0001, 1'b0}, // R4 user frozen
        {32'h1000_0000, 1'b0, 1'b1, 32'h0000_0001, 1'b0}, // R5 mark1 frozen
        {32'h1000_0000, 1'b0, 1'b0, 32'h0000_0001, 1'b1}, // R5 mark1, mark 0
        {32'h0800_0000, 1'b0, 1'b0, 32'h0000_0001, 1'b0}, // R5 mark0 frozen
        {32'h0800_0000, 1'b1, 1'b1, 32'h0000_0001, 1'b1}  // R5 mark0, mark 1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(4'd0, d); chk("R1 global", d, 32'h8000_0000);
        for (int i = 0; i < 4; i++) begin
            bus_rd(4'(1 + i), d); chk("R1 local", d, 32'hF800_0000);
            bus_rd(4'(5 + i), d); chk("R1 count", d, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 unmapped address
        bus_wr(4'd12, 32'hFFFF_FFFF);
        bus_rd(4'd12, d); chk("R2 unmapped read", d, 32'h0);
        bus_rd(4'd0, d);  chk("R2 unmapped write ignored", d, 32'h8000_0000);

        // R6 reserved bits are not stored
        bus_wr(4'd1, 32'hFFFF_FFFF);
        bus_rd(4'd1, d); chk("R6 reserved bits", d, 32'hFCFF_0000);

        // Table walk: R4/R5/R6 qualification and event select
        for (int v = 0; v < NV; v++) begin
            bus_wr(4'd0, 32'h0);
            bus_wr(4'd5, 32'h0);
            bus_wr(4'd1, VEC[v][66:35]);
            priv_sup = VEC[v][34];
            mark_in  = VEC[v][33];
            pulse(VEC[v][32:1]);
            bus_rd(4'd5, d);
            chk($sformatf("R4/R5/R6 vector %0d", v), d, {31'b0, VEC[v][0]});
        end
        priv_sup = 1'b0; mark_in = 1'b0;
        bus_rd(4'd6, d); chk("R2 counter1 untouched", d, 32'h0);

        // R3 freeze-all
        bus_wr(4'd1, 32'h0000_0000);
        bus_wr(4'd5, 32'd7);
        bus_wr(4'd0, 32'h8000_0000);
        pulse(32'h1); pulse(32'h1);
        bus_rd(4'd5, d); chk("R3 frozen count", d, 32'd7);
        bus_wr(4'd0, 32'h0);
        pulse(32'h1);
        bus_rd(4'd5, d); chk("R3 counts after unfreeze", d, 32'd8);

        // R7 wrap and write priority
        bus_wr(4'd5, 32'hFFFF_FFFF);
        pulse(32'h1);
        bus_rd(4'd5, d); chk("R7 wrap", d, 32'h0);
        @(negedge clk);
        evt_pulse = 32'h1; reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 32'd100;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
        bus_rd(4'd5, d); chk("R7 write wins", d, 32'd100);

        // R10/R8/R9 period, interrupt and auto-freeze
        bus_wr(4'd0, 32'h6000_0000);
        bus_wr(4'd1, 32'h0400_0000);
        bus_wr(4'd5, 32'h7FFF_FFFD);
        pulse(32'h1); pulse(32'h1);
        chk("R10 no condition before N", {31'b0, irq}, 32'h0);
        pulse(32'h1);
        chk("R10 condition after N", {31'b0, irq}, 32'h1);
        bus_rd(4'd5, d); chk("R10 count", d, 32'h8000_0000);
        @(negedge clk);
        bus_rd(4'd0, d); chk("R9 freeze-all set", d, 32'hE000_0000);
        pulse(32'h1);
        bus_rd(4'd5, d); chk("R9 counting halted", d, 32'h8000_0000);
        bus_wr(4'd0, 32'h6000_0000);
        bus_rd(4'd0, d); chk("R9 hw set wins", d, 32'hE000_0000);
        bus_wr(4'd5, 32'h0000_0010);
        chk("R8 irq cleared by rewrite", {31'b0, irq}, 32'h0);

        // R8 interrupt enable gating
        bus_wr(4'd0, 32'h0000_0000);
        bus_wr(4'd5, 32'h8000_0000);
        chk("R8 irq disabled", {31'b0, irq}, 32'h0);
        bus_wr(4'd0, 32'h4000_0000);
        chk("R8 irq enabled", {31'b0, irq}, 32'h1);
        bus_wr(4'd1, 32'h0000_0000);
        chk("R8 condition enable off", {31'b0, irq}, 32'h0);

        finish_run();
    end
endmodule